// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of parameterized width `N` (default 4) using radix-2 Booth recoding, one iteration at a time. It is split into a register datapath and a separate controller. The datapath keeps the multiplicand, an accumulator, the multiplier and one extra low bit. It has an add/subtract unit and an arithmetic right shift across the joined accumulator, multiplier and extra bit. A down counter in the datapath sets how many iterations run.

A start pulse while the controller is idle does two things. The operands are captured. Then the controller alternates between an operate step and a shift step until the counter is used up. The full 2N-bit product is then presented with a one-cycle done flag. The accumulator carries one guard bit above its N visible bits. Because of this, subtracting the most negative multiplicand cannot wrap. The controller's state code is brought out for debug. The reset is asynchronous and active high.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high, `stateCode` reads 0 (idle) and `done` is low at once, without waiting for a clock edge.
- R2: `stateCode` uses the codes idle=0, load=1, operate=2, shift=3, finish=4, and no other value appears. When `start` is high at a rising edge in idle, the code becomes 1 after that edge.
- R3: `start` has no effect unless the controller is in idle. A pulse during a run does not restart the run and does not change its product.
- R4: While `done` is high, `product` equals the signed product of `mcand` and `mplier` as captured at start, as a 2N-bit two's-complement value. In idle with `start` low, `product` holds its value.
- R5: The most negative operand gives the correct product in every pairing, including itself times itself (+2^(2N-2)).
- R6: `done` is high for exactly one cycle, with `stateCode`=4, and the next cycle is idle with `done` low.
- R7: Exactly N shift steps occur per run. `done` becomes visible after the (2N+1)-th rising edge following the edge that samples `start`.
- R8: With N=4, +3 times -2 gives -6 (`product` = 8'hFA).
- R9: Operands are captured only in the load step. Changing `mcand` or `mplier` later in the run has no effect on the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin a multiplication (acted on in idle only) |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| product | output | 2N | Signed product, valid while `done` is high |
| done | output | 1 | One-cycle completion flag |
| stateCode | output | 3 | Current controller state code for debug |

## Verification
The bench builds the block with N=4, its default. At that width, all 256 operand pairs can be swept in full. The sweep covers every sign combination, zero, and the most negative value -8 paired with everything, including -8 times -8. Every run also checks the exact cycle of completion, and it changes the operand inputs in mid-run. Separate runs apply a stray start pulse during operation and an asynchronous reset between clock edges.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD    = 3'd1,
    ST_OPERATE = 3'd2,
    ST_SHIFT   = 3'd3,
    ST_FINISH  = 3'd4
  } boothState_e;

  // strobes from controller to datapath
  typedef struct packed {
    logic loadEn;
    logic opEn;
    logic shiftEn;
  } boothCtrl_t;

endpackage

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int W = 5
) (
  input  logic [W-1:0] accIn,
  input  logic [W-1:0] operand,
  input  logic         doSub,
  output logic [W-1:0] result
);
  always_comb begin
    if (doSub) result = accIn - operand;
    else       result = accIn + operand;
  end
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int N = 4,
  localparam int ACC_W = N + 1,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  boothCtrl_t       ctrl,
  input  logic [N-1:0]     mcandIn,
  input  logic [N-1:0]     mplierIn,
  output logic             lastIter,
  output logic [2*N-1:0]   productOut
);
  localparam logic [CNT_W-1:0] ITERS = CNT_W'(N);

  logic [N-1:0]     mReg;
  logic [ACC_W-1:0] accReg;
  logic [N-1:0]     qReg;
  logic             qMinus;
  logic [CNT_W-1:0] iterCnt;

  logic [ACC_W-1:0] mExt;
  logic [ACC_W-1:0] aluOut;
  logic [1:0]       recode;
  logic             doArith;

  // guard bit: sign-extend the multiplicand into the wider accumulator
  assign mExt    = {mReg[N-1], mReg};
  assign recode  = {qReg[0], qMinus};
  assign doArith = recode[1] ^ recode[0];

  booth_addsub #(.W(ACC_W)) u_alu (
    .accIn  (accReg),
    .operand(mExt),
    .doSub  (recode[1]),
    .result (aluOut)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mReg    <= '0;
      accReg  <= '0;
      qReg    <= '0;
      qMinus  <= 1'b0;
      iterCnt <= '0;
    end else if (ctrl.loadEn) begin
      mReg    <= mcandIn;
      accReg  <= '0;
      qReg    <= mplierIn;
      qMinus  <= 1'b0;
      iterCnt <= ITERS;
    end else if (ctrl.opEn) begin
      if (doArith) accReg <= aluOut;
    end else if (ctrl.shiftEn) begin
      accReg  <= {accReg[ACC_W-1], accReg[ACC_W-1:1]};
      qReg    <= {accReg[0], qReg[N-1:1]};
      qMinus  <= qReg[0];
      iterCnt <= iterCnt - 1'b1;
    end
  end

  assign lastIter   = (iterCnt == CNT_W'(1));
  assign productOut = {accReg[N-1:0], qReg};

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        lastIter,
  output boothCtrl_t  ctrl,
  output logic        doneFlag,
  output logic [2:0]  stateOut
);
  boothState_e curState, nextState;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nextState;
  end

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE:    if (start) nextState = ST_LOAD;
      ST_LOAD:    nextState = ST_OPERATE;
      ST_OPERATE: nextState = ST_SHIFT;
      ST_SHIFT:   nextState = lastIter ? ST_FINISH : ST_OPERATE;
      ST_FINISH:  nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl.loadEn  = (curState == ST_LOAD);
    ctrl.opEn    = (curState == ST_OPERATE);
    ctrl.shiftEn = (curState == ST_SHIFT);
  end

  assign doneFlag = (curState == ST_FINISH);
  assign stateOut = curState;

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product,
  output logic           done,
  output logic [2:0]     stateCode
);
  boothCtrl_t ctrlBus;
  logic       lastIter;

  booth_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .lastIter(lastIter),
    .ctrl    (ctrlBus),
    .doneFlag(done),
    .stateOut(stateCode)
  );

  booth_datapath #(.N(N)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrlBus),
    .mcandIn   (mcand),
    .mplierIn  (mplier),
    .lastIter  (lastIter),
    .productOut(product)
  );

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int N = 4,
  localparam int SC_W = $clog2(N + 2) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           done,
  input logic [2:0]     stateCode,
  input logic [2*N-1:0] product
);
  logic [SC_W-1:0] shiftSeen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                     shiftSeen <= '0;
    else if (stateCode == 3'd1)  shiftSeen <= '0;
    else if (stateCode == 3'd3)  shiftSeen <= shiftSeen + 1'b1;
  end

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    stateCode <= 3'd4);

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd0 && start) |=> stateCode == 3'd1);

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (stateCode != 3'd0) |=> stateCode != 3'd1);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd0 && !start) |=> $stable(product));

  assert_single_done_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && stateCode == 3'd0));

  assert_shift_count_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> shiftSeen == SC_W'(N));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .stateCode(stateCode),
  .product  (product)
);

// File: tb/booth_seq_mult_bench.sv
module booth_seq_mult_bench;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [N-1:0]   mcand;
  logic [N-1:0]   mplier;
  logic [2*N-1:0] product;
  logic           done;
  logic [2:0]     stateCode;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  booth_seq_mult #(.N(N)) u_booth_seq_mult (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product), .done(done), .stateCode(stateCode)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one full run; disturbs operand inputs mid-run (R9), optional stray start (R3)
  task automatic runMul(input logic [N-1:0] a, input logic [N-1:0] b,
                        input bit strayStart, input string tag);
    int cyc;
    int expProd;
    int gotProd;
    expProd = int'($signed(a)) * int'($signed(b));
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(stateCode == 3'd1, "R2 load code after start", stateCode, 1);
    cyc = 0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      mcand  = ~a + N'(cyc);
      mplier = b ^ N'(cyc);
      if (strayStart && cyc == 3) start = 1'b1;
      if (strayStart && cyc == 4) start = 1'b0;
    end
    start = 1'b0;
    check(cyc == 2*N + 1, "R7 cycles to done", cyc, 2*N + 1);
    check(stateCode == 3'd4, "R6 finish code with done", stateCode, 4);
    gotProd = int'($signed(product));
    check(gotProd == expProd, tag, gotProd, expProd);
    @(negedge clk);
    check(!done && stateCode == 3'd0, "R6 done one cycle then idle",
          {done, stateCode}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int heldProd;
    rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
    #1;
    check(stateCode == 3'd0 && !done, "R1 reset state", {done, stateCode}, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: +3 times -2
    runMul(4'sd3, -4'sd2, 1'b0, "R8 +3*-2");
    check(product == 8'hFA, "R8 product bits", product, 8'hFA);

    // R4: product held in idle
    heldProd = product;
    repeat (4) @(negedge clk);
    check(product == 8'(heldProd), "R4 idle hold", product, heldProd);

    // R5: most negative squared
    runMul(4'b1000, 4'b1000, 1'b0, "R5 min*min");

    // R3: stray start during run
    runMul(-4'sd7, 4'sd5, 1'b1, "R3 stray start ignored");
    runMul(4'sd6, -4'sd8, 1'b1, "R3 stray start ignored");

    // R4/R5/R9: exhaustive sweep
    for (int i = 0; i < (1 << N); i++) begin
      for (int j = 0; j < (1 << N); j++) begin
        runMul(N'(i), N'(j), 1'b0, (i == 8 || j == 8) ? "R5 min sweep" : "R4 R9 sweep");
      end
    end

    // R1: asynchronous reset between edges mid-run
    @(negedge clk);
    mcand = 4'sd5; mplier = 4'sd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b1;
    #1;
    check(stateCode == 3'd0 && !done, "R1 async reset mid-run", {done, stateCode}, 0);
    @(negedge clk);
    rst = 1'b0;
    runMul(-4'sd1, -4'sd1, 1'b0, "R4 after reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule